// File: doc/BRIEF.md
# Multicycle 8-bit Accumulator Processor Core

This block is a small multicycle processor with two 8-bit accumulators, A and B. The pair also acts as one 16-bit register D, with A as the high byte and B as the low byte. The core reads an opcode byte, then reads its operand or address bytes one per bus cycle. It may then read a memory operand, do the operation, and write a result back to an accumulator or to memory. It runs load, add and store instructions in three addressing modes, plus a no-operation. The core halts on any byte it does not recognise.

The core drives a byte-wide synchronous memory through a 16-bit address, an 8-bit write bus and separate read and write strobes. Read data comes back on the clock edge after the read strobe. The accumulator pair and the condition-code register are brought out as ports so that the architectural state can be observed.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held, both strobes are low, `halted_err` is low and `acc_d` and `ccr` read zero. The first bus cycle after release is a read at parameter `RESET_PC`.
- R2: Every byte read at the program counter advances it by one. An extended-mode instruction reads the opcode, then the address high byte, then the address low byte, then the operand at that address. The next fetch is three bytes after the opcode.
- R3: Direct mode uses the single byte after the opcode as the address, with the upper address byte zero. Immediate mode takes the operand from the byte, or the two bytes with the high byte first, that follow the opcode.
- R4: The opcodes are: 0x86/0x96/0xB6 load A; 0xC6/0xD6 load B; 0xCC/0xDC load D. In each group the codes are immediate, then direct, then extended. Loading D writes its high byte into A and its low byte into B.
- R5: The 8-bit adds are 0x8B/0x9B/0xBB into A and 0xCB/0xDB into B. They set C (bit 0) to the carry out of bit 7, V (bit 1) to signed overflow, Z (bit 2) to a zero result, N (bit 3) to result bit 7 and H (bit 5) to the carry out of bit 3. Bits 7, 6 and 4 of `ccr` stay zero.
- R6: The 16-bit adds are 0xC3/0xD3 into D. They set C from the carry out of bit 15 and V from signed 16-bit overflow. N and Z come from the 16-bit result. H is left unchanged.
- R7: Loads set N and Z from the loaded value and clear V. They leave C and H unchanged.
- R8: The stores are 0x97/0xB7 (A), 0xD7 (B) and 0xDD (D). Each byte is written in one write-strobe cycle. D is written high byte at the address, then low byte at the address plus one. A store sets N and Z from the stored value, clears V, and leaves the accumulators unchanged.
- R9: Opcode 0x01 is one byte long and changes no accumulator and no flag.
- R10: Any other opcode halts the core. `halted_err` then stays high and no read or write cycle follows until reset. The accumulators are not changed.
- R11: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe; data arrives on the next edge |
| mem_wr | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read strobe |
| halted_err | output | 1 | High while halted on an undefined opcode |
| acc_d | output | 16 | Accumulator pair {A, B} |
| ccr | output | 8 | Condition codes S X H I N Z V C, bit 7 down to bit 0 |

## Verification
The assertions assume a memory that answers each read strobe with a byte on the following edge and never stalls. They also assume that reset is the only way out of the halted state. The bench memory model answers every read in the next cycle and places an undefined byte at the end of every program. Each run therefore ends in the halted state and is left only through reset. The bench writes each memory byte a program will touch before it releases reset, so no read returns an undriven value.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [1:0] {K_NOP, K_LD, K_ADD, K_ST} kind_t;
  typedef enum logic [1:0] {T_A, T_B, T_D} tgt_t;
  typedef enum logic [1:0] {M_NONE, M_IMM, M_DIR, M_EXT} mode_t;

  typedef struct packed {
    logic  valid;
    kind_t kind;
    tgt_t  tgt;
    mode_t mode;
  } dec_t;

  typedef enum logic [2:0] {
    S_FETCH, S_OP, S_B1, S_B2, S_M1, S_M2, S_W2, S_HALT
  } state_t;

  // condition-code bit positions
  localparam int CC_C = 0;
  localparam int CC_V = 1;
  localparam int CC_Z = 2;
  localparam int CC_N = 3;
  localparam int CC_H = 5;

  function automatic dec_t mk_dec(kind_t k, tgt_t t, mode_t m);
    dec_t d;
    d.valid = 1'b1;
    d.kind  = k;
    d.tgt   = t;
    d.mode  = m;
    return d;
  endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  kind_t             kind,
  input  logic              wide,
  input  logic [2*DW-1:0]   acc,
  input  logic [2*DW-1:0]   opnd,
  input  logic [7:0]        cc_in,
  output logic [2*DW-1:0]   res,
  output logic [7:0]        cc_out
);
  localparam int WW = 2 * DW;
  localparam int HB = DW / 2;

  logic [DW:0] sum_n;
  logic [WW:0] sum_w;
  logic [HB:0] sum_h;

  always_comb begin
    sum_n  = {1'b0, acc[DW-1:0]} + {1'b0, opnd[DW-1:0]};
    sum_w  = {1'b0, acc} + {1'b0, opnd};
    sum_h  = {1'b0, acc[HB-1:0]} + {1'b0, opnd[HB-1:0]};
    cc_out = cc_in;
    res    = acc;
    case (kind)
      K_LD: begin
        res          = wide ? opnd : {{DW{1'b0}}, opnd[DW-1:0]};
        cc_out[CC_V] = 1'b0;
      end
      K_ADD: begin
        if (wide) begin
          res          = sum_w[WW-1:0];
          cc_out[CC_C] = sum_w[WW];
          cc_out[CC_V] = (acc[WW-1] == opnd[WW-1]) && (sum_w[WW-1] != acc[WW-1]);
        end else begin
          res          = {{DW{1'b0}}, sum_n[DW-1:0]};
          cc_out[CC_C] = sum_n[DW];
          cc_out[CC_V] = (acc[DW-1] == opnd[DW-1]) && (sum_n[DW-1] != acc[DW-1]);
          cc_out[CC_H] = sum_h[HB];
        end
      end
      K_ST: cc_out[CC_V] = 1'b0;
      default: ;
    endcase
    if (kind != K_NOP) begin
      cc_out[CC_N] = wide ? res[WW-1] : res[DW-1];
      cc_out[CC_Z] = wide ? (res == '0) : (res[DW-1:0] == '0);
    end
  end

endmodule

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
(
  input  logic [7:0] opcode,
  output dec_t       dec
);

  always_comb begin
    dec = '0;
    case (opcode)
      8'h01: dec = mk_dec(K_NOP, T_A, M_NONE);
      8'h86: dec = mk_dec(K_LD,  T_A, M_IMM);
      8'h96: dec = mk_dec(K_LD,  T_A, M_DIR);
      8'hB6: dec = mk_dec(K_LD,  T_A, M_EXT);
      8'hC6: dec = mk_dec(K_LD,  T_B, M_IMM);
      8'hD6: dec = mk_dec(K_LD,  T_B, M_DIR);
      8'hCC: dec = mk_dec(K_LD,  T_D, M_IMM);
      8'hDC: dec = mk_dec(K_LD,  T_D, M_DIR);
      8'h8B: dec = mk_dec(K_ADD, T_A, M_IMM);
      8'h9B: dec = mk_dec(K_ADD, T_A, M_DIR);
      8'hBB: dec = mk_dec(K_ADD, T_A, M_EXT);
      8'hCB: dec = mk_dec(K_ADD, T_B, M_IMM);
      8'hDB: dec = mk_dec(K_ADD, T_B, M_DIR);
      8'hC3: dec = mk_dec(K_ADD, T_D, M_IMM);
      8'hD3: dec = mk_dec(K_ADD, T_D, M_DIR);
      8'h97: dec = mk_dec(K_ST,  T_A, M_DIR);
      8'hB7: dec = mk_dec(K_ST,  T_A, M_EXT);
      8'hD7: dec = mk_dec(K_ST,  T_B, M_DIR);
      8'hDD: dec = mk_dec(K_ST,  T_D, M_DIR);
      default: dec = '0;
    endcase
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [15:0] RESET_PC = 16'hC000
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            halted_err,
  output logic [2*DW-1:0] acc_d,
  output logic [7:0]      ccr
);
  localparam int WW = 2 * DW;

  // reset synchroniser: asynchronous assert, synchronous release
  logic rst_q1, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1     <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_q1     <= 1'b1;
      rst_core_n <= rst_q1;
    end
  end

  state_t        state, state_n;
  logic [AW-1:0] pc, pc_n, ea, ea_n, addr_c, eff;
  logic [DW-1:0] a, a_n, b, b_n, tmp, tmp_n, wdata_c;
  logic [7:0]    cc_n, cc_alu;
  dec_t          dec_q, dec_n, dec_in;
  logic          rd_c, wr_c, exec, mem_go, wide;
  logic [WW-1:0] opnd, sel_acc, res;

  acc_cpu_decode u_dec (.opcode(mem_rdata), .dec(dec_in));

  acc_cpu_alu #(.DW(DW)) u_alu (
    .kind(dec_q.kind), .wide(wide), .acc(sel_acc), .opnd(opnd),
    .cc_in(ccr), .res(res), .cc_out(cc_alu)
  );

  assign wide = (dec_q.tgt == T_D);

  always_comb begin
    case (dec_q.tgt)
      T_D:     sel_acc = {a, b};
      T_B:     sel_acc = {{DW{1'b0}}, b};
      default: sel_acc = {{DW{1'b0}}, a};
    endcase
  end

  // next-state and bus control
  always_comb begin
    state_n = state;
    pc_n    = pc;
    ea_n    = ea;
    tmp_n   = tmp;
    dec_n   = dec_q;
    addr_c  = pc;
    rd_c    = 1'b0;
    wr_c    = 1'b0;
    wdata_c = '0;
    exec    = 1'b0;
    opnd    = '0;
    mem_go  = 1'b0;
    eff     = '0;
    case (state)
      S_FETCH: begin
        rd_c    = 1'b1;
        pc_n    = pc + 1'b1;
        state_n = S_OP;
      end
      S_OP: begin
        dec_n = dec_in;
        if (!dec_in.valid) begin
          state_n = S_HALT;
        end else if (dec_in.kind == K_NOP) begin
          state_n = S_FETCH;
        end else begin
          rd_c    = 1'b1;
          pc_n    = pc + 1'b1;
          state_n = S_B1;
        end
      end
      S_B1: begin
        if (dec_q.mode == M_DIR) begin
          mem_go = 1'b1;
          eff    = {{(AW-DW){1'b0}}, mem_rdata};
        end else if (dec_q.mode == M_IMM && !wide) begin
          opnd    = {{DW{1'b0}}, mem_rdata};
          exec    = 1'b1;
          state_n = S_FETCH;
        end else begin
          tmp_n   = mem_rdata;
          rd_c    = 1'b1;
          pc_n    = pc + 1'b1;
          state_n = S_B2;
        end
      end
      S_B2: begin
        if (dec_q.mode == M_IMM) begin
          opnd    = {tmp, mem_rdata};
          exec    = 1'b1;
          state_n = S_FETCH;
        end else begin
          mem_go = 1'b1;
          eff    = {tmp, mem_rdata};
        end
      end
      S_M1: begin
        if (wide) begin
          tmp_n   = mem_rdata;
          rd_c    = 1'b1;
          addr_c  = ea + 1'b1;
          state_n = S_M2;
        end else begin
          opnd    = {{DW{1'b0}}, mem_rdata};
          exec    = 1'b1;
          state_n = S_FETCH;
        end
      end
      S_M2: begin
        opnd    = {tmp, mem_rdata};
        exec    = 1'b1;
        state_n = S_FETCH;
      end
      S_W2: begin
        wr_c    = 1'b1;
        addr_c  = ea + 1'b1;
        wdata_c = b;
        state_n = S_FETCH;
      end
      default: state_n = S_HALT;
    endcase

    // memory-operand phase shared by direct and extended modes
    if (mem_go) begin
      ea_n   = eff;
      addr_c = eff;
      if (dec_q.kind == K_ST) begin
        wr_c    = 1'b1;
        wdata_c = (dec_q.tgt == T_B) ? b : a;
        exec    = 1'b1;
        state_n = wide ? S_W2 : S_FETCH;
      end else begin
        rd_c    = 1'b1;
        state_n = S_M1;
      end
    end
  end

  // architectural write-back
  always_comb begin
    a_n  = a;
    b_n  = b;
    cc_n = ccr;
    if (exec) begin
      cc_n = cc_alu;
      case (dec_q.tgt)
        T_A:     a_n = res[DW-1:0];
        T_B:     b_n = res[DW-1:0];
        default: {a_n, b_n} = res;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state <= S_FETCH;
      pc    <= RESET_PC[AW-1:0];
      ea    <= '0;
      tmp   <= '0;
      dec_q <= '0;
      a     <= '0;
      b     <= '0;
      ccr   <= '0;
    end else begin
      state <= state_n;
      pc    <= pc_n;
      ea    <= ea_n;
      tmp   <= tmp_n;
      dec_q <= dec_n;
      if (exec) begin
        a   <= a_n;
        b   <= b_n;
        ccr <= cc_n;
      end
    end
  end

  assign mem_addr   = addr_c;
  assign mem_rd     = rd_c & rst_core_n;
  assign mem_wr     = wr_c & rst_core_n;
  assign mem_wdata  = wdata_c;
  assign halted_err = (state == S_HALT);
  assign acc_d      = {a, b};

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic            halted_err,
  input logic [2*DW-1:0] acc_d,
  input logic [7:0]      ccr
);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_err |-> (!mem_rd && !mem_wr));

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_err |=> halted_err);

  // R10
  halt_acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_err |=> $stable(acc_d));

  // R8
  store_acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> $stable(acc_d));

  // R5
  cc_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ccr[7:6] == 2'b00) && !ccr[4]);

endmodule

bind acc_cpu acc_cpu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .halted_err(halted_err), .acc_d(acc_d), .ccr(ccr)
);

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;
  localparam logic [15:0] P = 16'h0400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, halted_err;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] acc_d;
  logic [7:0]  ccr;

  always #5 clk = ~clk;

  acc_cpu #(.AW(16), .DW(8), .RESET_PC(P)) u_acc_cpu (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted_err(halted_err), .acc_d(acc_d), .ccr(ccr)
  );

  // memory model, 4 KiB aliased over the address space
  logic [7:0]  mem [4096];
  logic        ld_en = 1'b0;
  logic [15:0] ld_a = '0;
  logic [7:0]  ld_d = '0;
  logic [15:0] rlog [32];
  logic [15:0] wlog_a [8];
  logic [7:0]  wlog_d [8];
  int          rcnt, wcnt, overlap;

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
    else if (ld_en) mem[ld_a[11:0]] <= ld_d;
    if (!rst_n) begin
      rcnt <= 0;
      wcnt <= 0;
    end else begin
      if (mem_rd && rcnt < 32) begin
        rlog[rcnt] <= mem_addr;
        rcnt       <= rcnt + 1;
      end
      if (mem_wr && wcnt < 8) begin
        wlog_a[wcnt] <= mem_addr;
        wlog_d[wcnt] <= mem_wdata;
        wcnt         <= wcnt + 1;
      end
    end
  end

  initial overlap = 0;
  always @(negedge clk) if (mem_rd && mem_wr) overlap = overlap + 1;

  int n_checks = 0;
  int n_err    = 0;
  int cycles   = 0;
  logic done   = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    ld_en = 1'b1;
    ld_a  = a;
    ld_d  = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
  endtask

  task automatic run_to_halt(input string req);
    int n;
    rst_n = 1'b1;
    n = 0;
    while (!halted_err && n < 300) begin
      @(negedge clk);
      n++;
    end
    if (!halted_err) check(req, "run reaches halt", 32'd0, 32'd1);
    @(negedge clk);
  endtask

  function automatic logic [7:0] flags8(input logic [7:0] x, input logic [7:0] y);
    logic [8:0] s;
    logic h, v;
    s = {1'b0, x} + {1'b0, y};
    h = ({1'b0, x[3:0]} + {1'b0, y[3:0]}) > 5'd15;
    v = (x[7] == y[7]) && (s[7] != x[7]);
    return {2'b00, h, 1'b0, s[7], (s[7:0] == 8'd0), v, s[8]};
  endfunction

  initial begin
    logic [15:0] dv [8];
    dv[0] = 16'h0000; dv[1] = 16'h0001; dv[2] = 16'h7FFF; dv[3] = 16'h8000;
    dv[4] = 16'hFFFF; dv[5] = 16'h1234; dv[6] = 16'h80FF; dv[7] = 16'h00FF;

    // Extended load example: opcode, two address bytes, then the operand
    hold_reset();
    poke(P, 8'hB6); poke(P + 1, 8'h20); poke(P + 2, 8'h80); poke(P + 3, 8'h00);
    poke(16'h2080, 8'h19);
    run_to_halt("R2");
    check("R2", "ext fetch 0", {16'd0, rlog[0]}, {16'd0, P});
    check("R2", "ext fetch 1", {16'd0, rlog[1]}, {16'd0, P + 16'd1});
    check("R2", "ext fetch 2", {16'd0, rlog[2]}, {16'd0, P + 16'd2});
    check("R2", "ext operand addr", {16'd0, rlog[3]}, 32'h2080);
    check("R2", "next fetch at +3", {16'd0, rlog[4]}, {16'd0, P + 16'd3});
    check("R4", "A from ext load", {16'd0, acc_d}, 32'h1900);
    check("R10", "halt flag", {31'd0, halted_err}, 32'd1);

    // R1: reset state after a run left state behind
    hold_reset();
    @(negedge clk);
    check("R1", "rd low in reset", {31'd0, mem_rd}, 32'd0);
    check("R1", "wr low in reset", {31'd0, mem_wr}, 32'd0);
    check("R1", "err low in reset", {31'd0, halted_err}, 32'd0);
    check("R1", "acc clear", {16'd0, acc_d}, 32'd0);
    check("R1", "ccr clear", {24'd0, ccr}, 32'd0);
    poke(P, 8'h00);
    rst_n = 1'b1;
    begin
      int n;
      n = 0;
      while (!mem_rd && n < 10) begin
        @(negedge clk);
        n++;
      end
    end
    check("R1", "first read strobe", {31'd0, mem_rd}, 32'd1);
    check("R1", "first fetch address", {16'd0, mem_addr}, {16'd0, P});
    run_to_halt("R1");

    // R10: undefined opcode at start, bus stays quiet
    check("R10", "reads before halt", rcnt, 32'd1);
    repeat (20) @(negedge clk);
    check("R10", "no reads while halted", rcnt, 32'd1);
    check("R10", "no writes while halted", wcnt, 32'd0);
    check("R10", "still halted", {31'd0, halted_err}, 32'd1);

    // R10: undefined opcode after a load keeps A
    hold_reset();
    poke(P, 8'h86); poke(P + 1, 8'h12); poke(P + 2, 8'h42);
    run_to_halt("R10");
    check("R10", "A kept on halt", {16'd0, acc_d}, 32'h1200);

    // R3/R4/R5/R8: B via direct load, immediate add, direct store
    hold_reset();
    poke(P, 8'hD6); poke(P + 1, 8'h15); poke(P + 2, 8'hCB); poke(P + 3, 8'h7F);
    poke(P + 4, 8'hD7); poke(P + 5, 8'h40); poke(P + 6, 8'h00);
    poke(16'h0015, 8'h00);
    run_to_halt("R3");
    check("R3", "direct address upper zero", {16'd0, rlog[2]}, 32'h0015);
    check("R4", "B result", {16'd0, acc_d}, 32'h007F);
    check("R8", "store B address", {16'd0, wlog_a[0]}, 32'h0040);
    check("R8", "store B data", {24'd0, wlog_d[0]}, 32'h7F);
    check("R8", "single write", wcnt, 32'd1);
    check("R8", "reads around store", rcnt, 32'd8);
    check("R8", "flags after store", {24'd0, ccr}, 32'h00);

    // R7: load keeps C and H, clears V
    hold_reset();
    poke(P, 8'h86); poke(P + 1, 8'hFF); poke(P + 2, 8'h8B); poke(P + 3, 8'h01);
    poke(P + 4, 8'h86); poke(P + 5, 8'h80); poke(P + 6, 8'h00);
    run_to_halt("R7");
    check("R7", "ccr after load", {24'd0, ccr}, 32'h29);
    check("R7", "A after load", {16'd0, acc_d}, 32'h8000);

    // R8: store A extended
    hold_reset();
    poke(P, 8'h86); poke(P + 1, 8'h9C); poke(P + 2, 8'hB7); poke(P + 3, 8'h20);
    poke(P + 4, 8'h90); poke(P + 5, 8'h00);
    run_to_halt("R8");
    check("R8", "ext store address", {16'd0, wlog_a[0]}, 32'h2090);
    check("R8", "ext store data", {24'd0, wlog_d[0]}, 32'h9C);
    check("R8", "ext store flags", {24'd0, ccr}, 32'h08);
    check("R2", "fetch after ext store", {16'd0, rlog[5]}, {16'd0, P + 16'd5});

    // R4: load D direct, high byte first
    hold_reset();
    poke(P, 8'hDC); poke(P + 1, 8'h22); poke(P + 2, 8'h00);
    poke(16'h0022, 8'hAB); poke(16'h0023, 8'hCD);
    run_to_halt("R4");
    check("R4", "D value", {16'd0, acc_d}, 32'hABCD);
    check("R4", "D read hi addr", {16'd0, rlog[2]}, 32'h0022);
    check("R4", "D read lo addr", {16'd0, rlog[3]}, 32'h0023);
    check("R7", "D load flags", {24'd0, ccr}, 32'h08);

    // R9: no-operation bytes
    hold_reset();
    poke(P, 8'h01); poke(P + 1, 8'h01); poke(P + 2, 8'h86); poke(P + 3, 8'h55);
    poke(P + 4, 8'h00);
    run_to_halt("R9");
    check("R9", "A after nops", {16'd0, acc_d}, 32'h5500);
    check("R9", "one byte per nop", {16'd0, rlog[2]}, {16'd0, P + 16'd2});
    check("R9", "flags after nops", {24'd0, ccr}, 32'h00);

    // R5: 8-bit add sweep
    for (int x = 0; x < 256; x += 15) begin
      for (int y = 0; y < 256; y += 17) begin
        hold_reset();
        poke(P, 8'h86); poke(P + 1, 8'(x)); poke(P + 2, 8'h8B); poke(P + 3, 8'(y));
        poke(P + 4, 8'h00);
        run_to_halt("R5");
        check("R5", "8-bit sum", {16'd0, acc_d}, {16'd0, 8'(x + y), 8'h00});
        check("R5", "8-bit flags", {24'd0, ccr}, {24'd0, flags8(8'(x), 8'(y))});
      end
    end

    // R6/R8: 16-bit add sweep with H preset, then store D
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [16:0] s;
        logic        v;
        s = {1'b0, dv[i]} + {1'b0, dv[j]};
        v = (dv[i][15] == dv[j][15]) && (s[15] != dv[i][15]);
        hold_reset();
        poke(P, 8'h86); poke(P + 1, 8'h0F); poke(P + 2, 8'h8B); poke(P + 3, 8'h01);
        poke(P + 4, 8'hCC); poke(P + 5, dv[i][15:8]); poke(P + 6, dv[i][7:0]);
        poke(P + 7, 8'hD3); poke(P + 8, 8'h20);
        poke(P + 9, 8'hDD); poke(P + 10, 8'h30); poke(P + 11, 8'h00);
        poke(16'h0020, dv[j][15:8]); poke(16'h0021, dv[j][7:0]);
        run_to_halt("R6");
        check("R6", "16-bit sum", {16'd0, acc_d}, {16'd0, s[15:0]});
        check("R6", "16-bit flags (V cleared by store)", {24'd0, ccr},
              {24'd0, 2'b00, 1'b1, 1'b0, s[15], (s[15:0] == 16'd0), 1'b0, s[16]});
        check("R8", "D high byte addr", {16'd0, wlog_a[0]}, 32'h0030);
        check("R8", "D high byte data", {24'd0, wlog_d[0]}, {24'd0, s[15:8]});
        check("R8", "D low byte addr", {16'd0, wlog_a[1]}, 32'h0031);
        check("R8", "D low byte data", {24'd0, wlog_d[1]}, {24'd0, s[7:0]});
        if (i == j) begin
          hold_reset();
          poke(P, 8'hCC); poke(P + 1, dv[i][15:8]); poke(P + 2, dv[i][7:0]);
          poke(P + 3, 8'hC3); poke(P + 4, 8'h40); poke(P + 5, 8'h01);
          poke(P + 6, 8'h00);
          run_to_halt("R6");
          s = {1'b0, dv[i]} + 17'h04001;
          v = (dv[i][15] == 1'b0) && s[15];
          check("R6", "16-bit immediate add", {16'd0, acc_d}, {16'd0, s[15:0]});
          check("R6", "16-bit immediate flags", {24'd0, ccr},
                {24'd0, 4'b0000, s[15], (s[15:0] == 16'd0), v, s[16]});
        end
      end
    end

    check("R11", "strobes never overlap", overlap, 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

endmodule